// File: doc/BRIEF.md
# Multi-Format Serial Frame Transmitter

This block turns bytes into a serial bit stream on one transmit line. A 3-bit format code picks one of five framings:

- a clocked 8-bit shift mode with no framing bits, in which a serial clock output runs alongside the data;
- a 10-bit asynchronous frame;
- two 11-bit asynchronous frames, one with even parity and one with odd parity;
- an 11-bit multidrop frame, whose ninth bit tells listeners whether the byte is an address or data.

All five formats share one shifter, one bit timer and one state machine.

Bytes arrive through a valid/ready handshake into a single holding slot. An outside divider supplies a one-cycle bit-rate enable, `bit_tick`. A request input queues a frame of all ones of the current length. Two status outputs are provided. `empty` shows that the holding slot can take a byte. `idle` shows that no frame is on the line and none is waiting.

The control is a two-state machine:

- `ST_IDLE` holds the line high. It takes the transition **launch** to `ST_SEND` in the first cycle in which a byte is held or an all-ones frame is pending. At that point the frame is built and the format is fixed for the whole frame.
- `ST_SEND` shifts one bit out per bit period. It takes the transition **finish** back to `ST_IDLE` when the bit period of the last bit ends.

Top module: `sertx_frame`

## Requirements
- R1: After reset, and in the cycle after any reset asserted mid-frame, `tx_line` and `sclk_out` are 1 and `in_ready`, `empty` and `idle` are 1.
- R2: Format code 3'b010, and every code not listed in R3 to R5, sends 10 bits in this order: a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit.
- R3: Code 3'b100 sends 11 bits: start 0, 8 data bits LSB first, a parity bit and stop 1. The parity bit makes the count of ones over the data and parity even. Code 3'b101 has the same layout, with the parity bit making that count odd.
- R4: Code 3'b110 sends 11 bits: start 0, 8 data bits LSB first, the `in_type` value captured with the byte (1 = address, 0 = data), then stop 1.
- R5: Code 3'b000 sends exactly the 8 data bits LSB first, with no start or stop bit. Within each bit `sclk_out` is 0 for the first tick period and 1 for the second. In every other format `sclk_out` stays 1.
- R6: An asynchronous bit lasts 16 `bit_tick` pulses and a synchronous bit lasts 2. While `bit_tick` is 0, neither `tx_line` nor `sclk_out` changes during a frame.
- R7: A pulse on `idle_req` sends one frame of all ones, as long as the frame the current format defines, with `sclk_out` toggling as in R5 under code 3'b000. A byte already held is sent before a pending all-ones frame.
- R8: The format code is sampled only when a frame starts. Changing it during a frame does not alter that frame.
- R9: There is one holding slot. `in_ready` and `empty` are 1 exactly when the slot is free, and a byte accepted while a frame is running keeps both at 0. `idle` is 1 only with no frame running and nothing pending, and the line is 1 between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 3 | Frame format code, sampled at frame start |
| bit_tick | input | 1 | One-cycle bit-rate enable from the external divider |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_type | input | 1 | Multidrop type bit (1 = address) |
| in_ready | output | 1 | Holding slot free, byte accepted when in_valid is 1 |
| idle_req | input | 1 | Pulse that queues one all-ones frame |
| tx_line | output | 1 | Serial data line |
| sclk_out | output | 1 | Serial clock, active in the synchronous format only |
| empty | output | 1 | Holding slot empty |
| idle | output | 1 | No frame running and nothing pending |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse. They also assume that `in_valid`, `in_data`, `in_type`, `idle_req` and `fmt_sel` change only away from the clock edge. A change of `fmt_sel` must therefore reach the design as a clean level at launch.

The stimulus respects these assumptions by changing every input on the falling edge. It holds `bit_tick` at 1, except in one stretch where it is held at 0 on purpose. Because of that, the length of each bit in clock cycles is known exactly. The one format change made during a frame is applied only after launch, which is the case R8 covers.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        FK_SYNC,
        FK_ASYNC10,
        FK_PARITY,
        FK_MULTI
    } frame_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } tx_state_e;

    localparam logic [2:0] FMT_SYNC    = 3'b000;
    localparam logic [2:0] FMT_ASYNC10 = 3'b010;
    localparam logic [2:0] FMT_EVEN    = 3'b100;
    localparam logic [2:0] FMT_ODD     = 3'b101;
    localparam logic [2:0] FMT_MULTI   = 3'b110;

endpackage

// File: rtl/fmt_decode.sv
module fmt_decode
    import sertx_pkg::*;
(
    input  logic [2:0]  code,
    output frame_kind_e kind,
    output logic        odd_par
);
    always_comb begin
        odd_par = 1'b0;
        case (code)
            FMT_SYNC:  kind = FK_SYNC;
            FMT_EVEN:  kind = FK_PARITY;
            FMT_ODD: begin
                kind    = FK_PARITY;
                odd_par = 1'b1;
            end
            FMT_MULTI: kind = FK_MULTI;
            default:   kind = FK_ASYNC10;
        endcase
    end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic              type_bit,
    input  frame_kind_e       kind,
    input  logic              odd_par,
    input  logic              send_ones,
    output logic [DATA_W+2:0] frame,
    output logic [NB_W-1:0]   nbits
);
    always_comb begin
        frame = '1;
        nbits = NB_W'(DATA_W + 2);
        unique case (kind)
            FK_SYNC: begin
                frame[DATA_W-1:0] = data;
                nbits             = NB_W'(DATA_W);
            end
            FK_ASYNC10: begin
                frame[0]        = 1'b0;
                frame[DATA_W:1] = data;
                nbits           = NB_W'(DATA_W + 2);
            end
            FK_PARITY: begin
                frame[0]          = 1'b0;
                frame[DATA_W:1]   = data;
                frame[DATA_W+1]   = (^data) ^ odd_par;
                nbits             = NB_W'(DATA_W + 3);
            end
            FK_MULTI: begin
                frame[0]          = 1'b0;
                frame[DATA_W:1]   = data;
                frame[DATA_W+1]   = type_bit;
                nbits             = NB_W'(DATA_W + 3);
            end
        endcase
        if (send_ones) begin
            frame = '1;
        end
    end
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int OS_ASYNC = 16,
    parameter int OS_SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sync_mode,
    input  logic tick,
    output logic bit_end,
    output logic high_phase
);
    localparam int CW = (OS_ASYNC > 1) ? $clog2(OS_ASYNC) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic [CW-1:0] half;
    logic          at_last;

    always_comb begin
        lim_m1     = sync_mode ? CW'(OS_SYNC - 1) : CW'(OS_ASYNC - 1);
        half       = sync_mode ? CW'(OS_SYNC / 2) : CW'(OS_ASYNC / 2);
        at_last    = (cnt_q == lim_m1);
        bit_end    = run && tick && at_last;
        high_phase = (cnt_q >= half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OS_ASYNC = 16,
    parameter int OS_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_sel,
    input  logic              bit_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_type,
    output logic              in_ready,
    input  logic              idle_req,
    output logic              tx_line,
    output logic              sclk_out,
    output logic              empty,
    output logic              idle
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    tx_state_e           state_q, state_d;
    logic                hold_full;
    logic [DATA_W-1:0]   hold_data;
    logic                hold_type;
    logic                idle_pend;
    logic [FRAME_W-1:0]  sreg;
    logic [NB_W-1:0]     bits_left;
    logic                sync_q;

    frame_kind_e         kind;
    logic                odd_par;
    logic [FRAME_W-1:0]  frame_vec;
    logic [NB_W-1:0]     frame_len;
    logic                bit_end;
    logic                high_phase;
    logic                busy;
    logic                frame_start;
    logic                last_bit;
    logic                start_is_sync;
    logic                take_ones;

    fmt_decode u_dec (
        .code    (fmt_sel),
        .kind    (kind),
        .odd_par (odd_par)
    );

    frame_builder #(
        .DATA_W (DATA_W),
        .NB_W   (NB_W)
    ) u_build (
        .data      (hold_data),
        .type_bit  (hold_type),
        .kind      (kind),
        .odd_par   (odd_par),
        .send_ones (take_ones),
        .frame     (frame_vec),
        .nbits     (frame_len)
    );

    bit_timer #(
        .OS_ASYNC (OS_ASYNC),
        .OS_SYNC  (OS_SYNC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy),
        .sync_mode  (sync_q),
        .tick       (bit_tick),
        .bit_end    (bit_end),
        .high_phase (high_phase)
    );

    // Control decode
    always_comb begin
        busy          = (state_q == ST_SEND);
        frame_start   = (state_q == ST_IDLE) && (hold_full || idle_pend);
        take_ones     = !hold_full;
        start_is_sync = (kind == FK_SYNC);
        last_bit      = bit_end && (bits_left == NB_W'(1));
    end

    // Next state: launch and finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_start) state_d = ST_SEND;
            ST_SEND: if (last_bit)    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Holding slot and pending all-ones request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
            hold_type <= 1'b0;
            idle_pend <= 1'b0;
        end else begin
            if (frame_start && hold_full) begin
                hold_full <= 1'b0;
            end else if (in_valid && !hold_full) begin
                hold_full <= 1'b1;
                hold_data <= in_data;
                hold_type <= in_type;
            end
            idle_pend <= (idle_pend && !(frame_start && take_ones)) || idle_req;
        end
    end

    // Shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '1;
            bits_left <= '0;
            sync_q    <= 1'b0;
        end else if (frame_start) begin
            sreg      <= frame_vec;
            bits_left <= frame_len;
            sync_q    <= start_is_sync;
        end else if (bit_end) begin
            sreg      <= {1'b1, sreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        in_ready = !hold_full;
        empty    = !hold_full;
        idle     = !busy && !hold_full && !idle_pend;
        tx_line  = busy ? sreg[0] : 1'b1;
        sclk_out = (busy && sync_q) ? high_phase : 1'b1;
    end
endmodule

// File: rtl/sertx_frame_chk.sv
module sertx_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic in_valid,
    input logic in_ready,
    input logic empty,
    input logic idle,
    input logic tx_line,
    input logic sclk_out,
    input logic busy,
    input logic frame_start,
    input logic start_is_sync,
    input logic hold_full
);
    assert_line_high_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (tx_line && sclk_out));

    assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !empty);

    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(tx_line) && $stable(sclk_out)));

    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && hold_full && !start_is_sync) |=> !tx_line);

    assert_sync_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && start_is_sync) |=> !sclk_out);

    assert_ones_frame_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !hold_full) |=> tx_line);
endmodule

bind sertx_frame sertx_frame_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .empty         (empty),
    .idle          (idle),
    .tx_line       (tx_line),
    .sclk_out      (sclk_out),
    .busy          (busy),
    .frame_start   (frame_start),
    .start_is_sync (start_is_sync),
    .hold_full     (hold_full)
);

// File: tb/sim_sertx_frame.sv
`timescale 1ns/1ps
module sim_sertx_frame;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fmt_sel = 3'b010;
    logic       bit_tick = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_type = 1'b0;
    logic       in_ready, idle_req, tx_line, sclk_out, empty, idle;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    initial idle_req = 1'b0;
    always #5 clk = ~clk;

    sertx_frame u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bit_tick(bit_tick),
        .in_valid(in_valid), .in_data(in_data), .in_type(in_type),
        .in_ready(in_ready), .idle_req(idle_req), .tx_line(tx_line),
        .sclk_out(sclk_out), .empty(empty), .idle(idle)
    );

    typedef struct packed {
        logic [2:0] fmt;
        logic       typ;
        logic [7:0] data;
        logic [3:0] len;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 1'b0, 8'hA5, 4'd8},
        '{3'b010, 1'b0, 8'h3C, 4'd10},
        '{3'b100, 1'b0, 8'h07, 4'd11},
        '{3'b101, 1'b0, 8'h07, 4'd11},
        '{3'b110, 1'b1, 8'h81, 4'd11},
        '{3'b110, 1'b0, 8'h55, 4'd11},
        '{3'b011, 1'b0, 8'hF0, 4'd10},
        '{3'b111, 1'b0, 8'h00, 4'd10},
        '{3'b100, 1'b0, 8'h00, 4'd11},
        '{3'b101, 1'b0, 8'h00, 4'd11}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] f, input bit ones);
        if (ones) return "R7";
        case (f)
            3'b000: return "R5";
            3'b100, 3'b101: return "R3";
            3'b110: return "R4";
            default: return "R2";
        endcase
    endfunction

    // Expected line bits, first bit sent in bit 0
    function automatic logic [10:0] exp_frame(input logic [2:0] f, input logic t, input logic [7:0] d, input bit ones);
        logic [10:0] v;
        v = '1;
        if (!ones) begin
            case (f)
                3'b000: v[7:0] = d;
                3'b100: begin v[0] = 1'b0; v[8:1] = d; v[9] = ^d; end
                3'b101: begin v[0] = 1'b0; v[8:1] = d; v[9] = ~^d; end
                3'b110: begin v[0] = 1'b0; v[8:1] = d; v[9] = t; end
                default: begin v[0] = 1'b0; v[8:1] = d; end
            endcase
        end
        return v;
    endfunction

    // Launch one frame and observe it bit by bit (bit_tick held at 1)
    task automatic run_frame(input logic [2:0] f, input logic t, input logic [7:0] d,
                             input bit ones, input logic [2:0] f_later, input int len, input string req);
        logic [10:0] got;
        logic [10:0] exp;
        logic [10:0] mask;
        bit clk_ok, stable_ok, busy_ok;
        logic cur;
        int os;
        os = (f == 3'b000) ? 2 : 16;
        got = '1;
        clk_ok = 1'b1;
        stable_ok = 1'b1;
        busy_ok = 1'b1;
        cur = 1'b1;
        @(negedge clk);
        fmt_sel = f;
        if (ones) begin
            idle_req = 1'b1;
        end else begin
            in_valid = 1'b1;
            in_data = d;
            in_type = t;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        idle_req = 1'b0;
        @(posedge clk);
        for (int b = 0; b < len; b++) begin
            for (int j = 0; j < os; j++) begin
                @(negedge clk);
                if (b == 0 && j == 0) fmt_sel = f_later;
                if (j == 0) cur = tx_line;
                else if (tx_line !== cur) stable_ok = 1'b0;
                if (j == os / 2) got[b] = tx_line;
                if (sclk_out !== ((f == 3'b000) ? (j >= os / 2) : 1'b1)) clk_ok = 1'b0;
                if (idle !== 1'b0) busy_ok = 1'b0;
                @(posedge clk);
            end
        end
        mask = 11'((1 << len) - 1);
        exp = exp_frame(f, t, d, ones) & mask;
        chk((got & mask) === exp, req, 32'(got & mask), 32'(exp));
        chk(clk_ok, (f == 3'b000) ? "R5 sclk phases" : "R5 sclk held high", 32'(clk_ok), 32'd1);
        chk(stable_ok, "R6 bit length in ticks", 32'(stable_ok), 32'd1);
        chk(busy_ok, "R9 idle low during frame", 32'(busy_ok), 32'd1);
        @(negedge clk);
        chk(tx_line === 1'b1 && idle === 1'b1, "R9 line high after frame",
            32'({tx_line, idle}), 32'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tx_line, sclk_out, in_ready, empty, idle} === 5'b11111, "R1 reset outputs",
            32'({tx_line, sclk_out, in_ready, empty, idle}), 32'h1F);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Table of formats
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i].fmt, VECS[i].typ, VECS[i].data, 1'b0, VECS[i].fmt,
                      int'(VECS[i].len), req_of(VECS[i].fmt, 1'b0));
        end

        // R7: all-ones frames in async, parity and sync formats
        run_frame(3'b010, 1'b0, 8'h00, 1'b1, 3'b010, 10, "R7 ones frame async");
        run_frame(3'b101, 1'b0, 8'h00, 1'b1, 3'b101, 11, "R7 ones frame parity");
        run_frame(3'b000, 1'b0, 8'h00, 1'b1, 3'b000, 8, "R7 ones frame sync");

        // R8: format change during a frame
        run_frame(3'b100, 1'b0, 8'h07, 1'b0, 3'b000, 11, "R8 format held in frame");
        run_frame(3'b000, 1'b0, 8'h3A, 1'b0, 3'b110, 8, "R8 format held in sync frame");

        // R6: tick held low freezes the line
        @(negedge clk);
        fmt_sel = 3'b010;
        in_valid = 1'b1;
        in_data = 8'h0F;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
        begin
            logic t0, s0;
            bit frozen;
            t0 = tx_line;
            s0 = sclk_out;
            frozen = 1'b1;
            repeat (40) begin
                @(negedge clk);
                if (tx_line !== t0 || sclk_out !== s0) frozen = 1'b0;
            end
            chk(frozen, "R6 no tick no change", 32'(frozen), 32'd1);
        end
        bit_tick = 1'b1;
        n = 0;
        while (!idle && n < 400) begin @(negedge clk); n++; end

        // R9 and R7 ordering: byte then all-ones frame queued behind a running frame
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'hFF;
        idle_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        idle_req = 1'b0;
        chk(in_ready === 1'b0 && empty === 1'b0, "R9 slot full while sending",
            32'({in_ready, empty}), 32'b00);
        n = 0;
        while (tx_line !== 1'b0 && n < 400) begin @(negedge clk); n++; end
        n = 0;
        while (idle !== 1'b1 && n < 1000) begin @(posedge clk); @(negedge clk); n++; end
        chk(n == 321, "R7 byte before ones frame", 32'(n), 32'd321);

        // R1: reset during a frame
        @(negedge clk);
        fmt_sel = 3'b110;
        in_valid = 1'b1;
        in_data = 8'h00;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({tx_line, sclk_out, in_ready, empty, idle} === 5'b11111, "R1 reset mid-frame",
            32'({tx_line, sclk_out, in_ready, empty, idle}), 32'h1F);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        run_frame(3'b010, 1'b0, 8'hC3, 1'b0, 3'b010, 10, "R2 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule